// File: doc/BRIEF.md
# DDR2 Read Command Rule Checker

This block is a passive monitor that sits beside a DDR2-style command bus. Every clock it reads the command, the bank it targets, and the programmed burst length and additive latency. It remembers which banks are open, how many clocks have passed since the last read, which bank that read targeted, and whether it carried auto-precharge. From these it decides whether the current command breaks one of the read-burst sequencing rules.

A read burst of eight may be cut short only by another read issued exactly two clocks after it. Reads closer together than that are illegal, and so is a read three clocks after a burst of eight. A write or precharge may not cut into a running burst. A precharge to the bank just read must wait the additive latency plus half the programmed burst length. This spacing is set by the programmed length, never by a truncated one. Reads must target an activated bank, and a read with auto-precharge closes its own bank once that same spacing has elapsed.

The first violation raises a sticky flag and a reason code. Both hold until reset, so a verification environment can sample them at any time after the event.

Top module: `ddr2_rd_rule_mon`

## Requirements
- R1: After reset the error flag is 0, the reason code is 0, every bank counts as closed and no earlier read is remembered.
- R2: Command codes are NOP=0, ACTIVATE=1, READ=2, READ with auto-precharge=3, WRITE=4, PRECHARGE=5; codes 6 and 7 act as NOP. A read of either kind to a bank not currently activated is a violation with reason code 1.
- R3: With either burst length, a read issued one clock after the previous read is a violation with reason code 2.
- R4: With burst length 8 (bl8_i=1), a read issued three clocks after the previous read gives reason code 2; a read two clocks after (an interrupt) or four or more clocks after is legal.
- R5: With burst length 4 (bl8_i=0), a read issued two or more clocks after the previous read is legal.
- R6: With burst length 8, a read two clocks after a read that carried auto-precharge gives reason code 3; a read with auto-precharge interrupting a plain read is legal.
- R7: A write issued fewer than BL/2 clocks after the last read gives reason code 4.
- R8: A precharge to any bank issued fewer than BL/2 clocks after the last read gives reason code 5.
- R9: A precharge to the bank of the last read, issued at least BL/2 but fewer than AL+BL/2 clocks after it, gives reason code 6, with BL the programmed length even after an interrupt. At exactly AL+BL/2 clocks it is legal.
- R10: A read with auto-precharge closes its bank AL+BL/2 clocks after issue. The bank is still open one clock earlier. A new auto-precharge read while one is pending closes the earlier bank at once.
- R11: The flag and code appear on the clock after the offending command. The first violation's code is held, and later violations are ignored until reset.
- R12: When one command breaks several rules, the lowest reason code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code (see R2) |
| bank_i | input | BANK_W (3) | Target bank |
| bl8_i | input | 1 | Programmed burst length: 1 = eight, 0 = four |
| al_i | input | AL_W (3) | Programmed additive latency in clocks |
| err_o | output | 1 | Sticky violation flag |
| err_code_o | output | 3 | Reason code of the first violation |

## Verification
Every result of this block is due exactly one clock after the command that causes it, because only the error latch lies between the command inputs and the outputs. Bank closure from auto-precharge follows AL+BL/2 clocks after its read, and it shows only through the code of a later read. The bench drives each command on a falling edge and lets one rising edge pass. On the next falling edge it compares the outputs with a reference model stepped on that same edge. Directed sequences place reads, writes and precharges at the exact clock distances named in the requirements, one on each side of every boundary.

// File: rtl/ddr2_rd_mon_pkg.sv
package ddr2_rd_mon_pkg;

    localparam logic [2:0] OP_NOP = 3'd0;
    localparam logic [2:0] OP_ACT = 3'd1;
    localparam logic [2:0] OP_RD  = 3'd2;
    localparam logic [2:0] OP_RDA = 3'd3;
    localparam logic [2:0] OP_WR  = 3'd4;
    localparam logic [2:0] OP_PRE = 3'd5;

    typedef enum logic [2:0] {
        VIOL_NONE      = 3'd0,
        VIOL_CLOSED    = 3'd1,
        VIOL_SPACING   = 3'd2,
        VIOL_AP_INTR   = 3'd3,
        VIOL_WR_BURST  = 3'd4,
        VIOL_PRE_BURST = 3'd5,
        VIOL_PRE_EARLY = 3'd6
    } viol_e;

    typedef struct packed {
        logic act;
        logic rd;
        logic ap;
        logic wr;
        logic pre;
    } op_dec_t;

    function automatic op_dec_t decode_op(logic [2:0] c);
        op_dec_t d;
        d.act = (c == OP_ACT);
        d.rd  = (c == OP_RD) || (c == OP_RDA);
        d.ap  = (c == OP_RDA);
        d.wr  = (c == OP_WR);
        d.pre = (c == OP_PRE);
        return d;
    endfunction

endpackage

// File: rtl/mon_bank_track.sv
module mon_bank_track
    import ddr2_rd_mon_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 3,
    parameter int AL_W      = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  op_dec_t              op_i,
    input  logic [BANK_W-1:0]    bank_i,
    input  logic                 bl8_i,
    input  logic [AL_W-1:0]      al_i,
    output logic [NUM_BANKS-1:0] open_o
);
    localparam int CW = AL_W + 2;

    typedef struct packed {
        logic [NUM_BANKS-1:0] open;
        logic                 pend;
        logic [BANK_W-1:0]    pbank;
        logic [CW-1:0]        pcnt;
    } trk_t;

    trk_t s_d, s_q;
    logic [CW-1:0] ap_span;

    assign ap_span = CW'(al_i) + (bl8_i ? CW'(4) : CW'(2));

    always_comb begin
        s_d = s_q;
        if (s_q.pend && s_q.pcnt == CW'(1)) begin
            s_d.open[s_q.pbank] = 1'b0;
            s_d.pend            = 1'b0;
        end else if (s_q.pend) begin
            s_d.pcnt = s_q.pcnt - CW'(1);
        end
        if (op_i.rd && op_i.ap) begin
            if (s_q.pend) begin
                s_d.open[s_q.pbank] = 1'b0;
            end
            s_d.pend  = 1'b1;
            s_d.pbank = bank_i;
            s_d.pcnt  = ap_span - CW'(1);
        end
        if (op_i.pre) begin
            s_d.open[bank_i] = 1'b0;
        end
        if (op_i.act) begin
            s_d.open[bank_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign open_o = s_q.open;

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        op_i.act |=> open_o[$past(bank_i)]); // R2
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        op_i.pre |=> !open_o[$past(bank_i)]); // R2
    AST_AP_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && s_q.pcnt == CW'(1) && !(op_i.act && bank_i == s_q.pbank))
        |=> !open_o[$past(s_q.pbank)]); // R10
endmodule

// File: rtl/mon_read_timer.sv
module mon_read_timer
    import ddr2_rd_mon_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int AGE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_dec_t           op_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic [AGE_W-1:0]  age_o,
    output logic [BANK_W-1:0] last_bank_o,
    output logic              last_ap_o
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    typedef struct packed {
        logic [AGE_W-1:0]  age;
        logic [BANK_W-1:0] bank;
        logic              ap;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (op_i.rd) begin
            s_d.age  = AGE_W'(1);
            s_d.bank = bank_i;
            s_d.ap   = op_i.ap;
        end else if (s_q.age != AGE_MAX) begin
            s_d.age = s_q.age + AGE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.age  <= AGE_MAX;
            s_q.bank <= '0;
            s_q.ap   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign age_o       = s_q.age;
    assign last_bank_o = s_q.bank;
    assign last_ap_o   = s_q.ap;

    AST_AGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        op_i.rd |=> (age_o == AGE_W'(1) && last_bank_o == $past(bank_i))); // R3
    AST_AGE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        age_o != '0); // R1
endmodule

// File: rtl/mon_rule_eval.sv
module mon_rule_eval
    import ddr2_rd_mon_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 3,
    parameter int AL_W      = 3,
    parameter int AGE_W     = 5
) (
    input  op_dec_t              op_i,
    input  logic [BANK_W-1:0]    bank_i,
    input  logic                 bl8_i,
    input  logic [AL_W-1:0]      al_i,
    input  logic [NUM_BANKS-1:0] open_i,
    input  logic [AGE_W-1:0]     age_i,
    input  logic [BANK_W-1:0]    last_bank_i,
    input  logic                 last_ap_i,
    output viol_e                viol_o
);
    logic [AGE_W-1:0] half;
    logic [AGE_W-1:0] pre_span;

    assign half     = bl8_i ? AGE_W'(4) : AGE_W'(2);
    assign pre_span = AGE_W'(al_i) + half;

    always_comb begin
        viol_o = VIOL_NONE;
        if (op_i.rd) begin
            if (!open_i[bank_i]) begin
                viol_o = VIOL_CLOSED;
            end else if (age_i == AGE_W'(1)) begin
                viol_o = VIOL_SPACING;
            end else if (bl8_i && age_i == AGE_W'(3)) begin
                viol_o = VIOL_SPACING;
            end else if (bl8_i && age_i == AGE_W'(2) && last_ap_i) begin
                viol_o = VIOL_AP_INTR;
            end
        end else if (op_i.wr) begin
            if (age_i < half) begin
                viol_o = VIOL_WR_BURST;
            end
        end else if (op_i.pre) begin
            if (age_i < half) begin
                viol_o = VIOL_PRE_BURST;
            end else if (bank_i == last_bank_i && age_i < pre_span) begin
                viol_o = VIOL_PRE_EARLY;
            end
        end
    end

    always_comb begin
        AST_QUIET_ON_NOP: assert ((op_i.rd || op_i.wr || op_i.pre) || viol_o == VIOL_NONE); // R12
    end
endmodule

// File: rtl/ddr2_rd_rule_mon.sv
module ddr2_rd_rule_mon
    import ddr2_rd_mon_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int AL_W      = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2:0]                   cmd_i,
    input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
    input  logic                         bl8_i,
    input  logic [AL_W-1:0]              al_i,
    output logic                         err_o,
    output logic [2:0]                   err_code_o
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int AGE_W  = $clog2((1 << AL_W) + 4) + 1;

    typedef struct packed {
        logic  flag;
        viol_e code;
    } latch_t;

    op_dec_t              op;
    logic [NUM_BANKS-1:0] open_w;
    logic [AGE_W-1:0]     age_w;
    logic [BANK_W-1:0]    last_bank_w;
    logic                 last_ap_w;
    viol_e                viol_w;
    latch_t               l_d, l_q;

    assign op = decode_op(cmd_i);

    mon_bank_track #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .AL_W(AL_W)) i_track (
        .clk(clk), .rst_n(rst_n), .op_i(op), .bank_i(bank_i),
        .bl8_i(bl8_i), .al_i(al_i), .open_o(open_w)
    );

    mon_read_timer #(.BANK_W(BANK_W), .AGE_W(AGE_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .op_i(op), .bank_i(bank_i),
        .age_o(age_w), .last_bank_o(last_bank_w), .last_ap_o(last_ap_w)
    );

    mon_rule_eval #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .AL_W(AL_W), .AGE_W(AGE_W)) i_eval (
        .op_i(op), .bank_i(bank_i), .bl8_i(bl8_i), .al_i(al_i),
        .open_i(open_w), .age_i(age_w), .last_bank_i(last_bank_w),
        .last_ap_i(last_ap_w), .viol_o(viol_w)
    );

    always_comb begin
        l_d = l_q;
        if (!l_q.flag && viol_w != VIOL_NONE) begin
            l_d.flag = 1'b1;
            l_d.code = viol_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q.flag <= 1'b0;
            l_q.code <= VIOL_NONE;
        end else begin
            l_q <= l_d;
        end
    end

    assign err_o      = l_q.flag;
    assign err_code_o = l_q.code;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (err_o && $stable(err_code_o))); // R11
    AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && viol_w != VIOL_NONE) |=> (err_o && err_code_o == $past(viol_w))); // R11
    AST_FLAG_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o == (err_code_o != 3'd0)); // R1
endmodule

// File: tb/test_ddr2_rd_rule_mon.sv
module test_ddr2_rd_rule_mon;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [2:0] bank = 3'd0;
    logic       bl8 = 1'b0;
    logic [2:0] al = 3'd0;
    logic       err;
    logic [2:0] code;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    logic [NB-1:0] m_open;
    int  m_age, m_lbank, m_pbank, m_pcnt;
    bit  m_lap, m_pend, m_err;
    int  m_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr2_rd_rule_mon i_ddr2_rd_rule_mon (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank),
        .bl8_i(bl8), .al_i(al), .err_o(err), .err_code_o(code)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rule_code(input int c, input int b);
        int half = bl8 ? 4 : 2;
        int span = int'(al) + half;
        bit is_rd = (c == 2) || (c == 3);
        if (is_rd) begin
            if (!m_open[b]) return 1;
            if (m_age == 1) return 2;
            if (bl8 && m_age == 3) return 2;
            if (bl8 && m_age == 2 && m_lap) return 3;
        end else if (c == 4) begin
            if (m_age < half) return 4;
        end else if (c == 5) begin
            if (m_age < half) return 5;
            if (b == m_lbank && m_age < span) return 6;
        end
        return 0;
    endfunction

    task automatic model_step(input int c, input int b);
        int v = rule_code(c, b);
        bit old_pend = m_pend;
        int old_pb = m_pbank;
        if (!m_err && v != 0) begin
            m_err = 1'b1;
            m_code = v;
        end
        if (m_pend && m_pcnt == 1) begin
            m_open[m_pbank] = 1'b0;
            m_pend = 1'b0;
        end else if (m_pend) begin
            m_pcnt--;
        end
        if (c == 3) begin
            if (old_pend) m_open[old_pb] = 1'b0;
            m_pend = 1'b1;
            m_pbank = b;
            m_pcnt = int'(al) + (bl8 ? 4 : 2) - 1;
        end
        if (c == 5) m_open[b] = 1'b0;
        if (c == 1) m_open[b] = 1'b1;
        if (c == 2 || c == 3) begin
            m_age = 1;
            m_lbank = b;
            m_lap = (c == 3);
        end else if (m_age < 31) begin
            m_age++;
        end
    endtask

    task automatic do_reset(input bit b8, input int a);
        rst_n = 1'b0;
        cmd = 3'd0;
        bank = 3'd0;
        bl8 = b8;
        al = 3'(a);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_open = '0; m_age = 31; m_lbank = 0; m_lap = 0;
        m_pend = 0; m_pbank = 0; m_pcnt = 0; m_err = 0; m_code = 0;
        check(err == 1'b0 && code == 3'd0, "R1 reset state", int'(code), 0);
    endtask

    task automatic issue(input int c, input int b);
        cmd = 3'(c);
        bank = 3'(b);
        @(posedge clk);
        model_step(c, b);
        @(negedge clk);
        check(err == m_err && int'(code) == m_code, "MODEL R11", int'(code), m_code);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) issue(0, 0);
    endtask

    task automatic expect_code(input int exp, input string tag);
        check(int'(code) == exp && err == (exp != 0), tag, int'(code), exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);

        // R1 / R2: banks closed after reset
        do_reset(1'b0, 0);
        issue(2, 0);
        expect_code(1, "R1 R2 read after reset hits closed bank");

        // R2: wrong bank
        do_reset(1'b0, 0);
        issue(1, 2); issue(0, 0); issue(2, 3);
        expect_code(1, "R2 read to bank never activated");

        // R3: BL4 back-to-back
        do_reset(1'b0, 0);
        issue(1, 0); issue(0, 0); issue(2, 0);
        expect_code(0, "R11 no flag before offending command");
        issue(2, 0);
        expect_code(2, "R3 read one clock after read");

        // R4: BL8 gap of three
        do_reset(1'b1, 0);
        issue(1, 0); issue(2, 0); nops(2); issue(2, 0);
        expect_code(2, "R4 read three clocks after BL8 read");

        // R4: legal interrupt at two and spacing of four
        do_reset(1'b1, 0);
        issue(1, 0); issue(1, 1); issue(2, 0); issue(0, 0); issue(2, 1);
        nops(3); issue(2, 0);
        expect_code(0, "R4 interrupt at two and read at four are legal");

        // R5: BL4 spacing two and three
        do_reset(1'b0, 0);
        issue(1, 0); issue(2, 0); issue(0, 0); issue(2, 0); nops(2); issue(2, 0);
        expect_code(0, "R5 BL4 reads two or more apart");

        // R6: interrupting an auto-precharge read
        do_reset(1'b1, 0);
        issue(1, 0); issue(3, 0); issue(0, 0); issue(2, 0);
        expect_code(3, "R6 interrupt of auto-precharge read");
        do_reset(1'b1, 0);
        issue(1, 0); issue(1, 1); issue(2, 0); issue(0, 0); issue(3, 1);
        expect_code(0, "R6 auto-precharge read may interrupt");

        // R7: write into burst
        do_reset(1'b1, 0);
        issue(1, 0); issue(2, 0); nops(2); issue(4, 0);
        expect_code(4, "R7 write three clocks after BL8 read");
        do_reset(1'b1, 0);
        issue(1, 0); issue(2, 0); nops(3); issue(4, 0);
        expect_code(0, "R7 write four clocks after BL8 read");

        // R8: precharge of another bank inside burst
        do_reset(1'b1, 0);
        issue(1, 0); issue(1, 1); issue(2, 0); issue(0, 0); issue(5, 1);
        expect_code(5, "R8 precharge during burst");

        // R9: precharge spacing from programmed length after interrupt
        do_reset(1'b1, 2);
        issue(1, 0); issue(2, 0); issue(0, 0); issue(2, 0); nops(4); issue(5, 0);
        expect_code(6, "R9 precharge at AL+BL/2-1");
        do_reset(1'b1, 2);
        issue(1, 0); issue(2, 0); issue(0, 0); issue(2, 0); nops(5); issue(5, 0);
        expect_code(0, "R9 precharge at AL+BL/2");

        // R10: auto-precharge closes its bank
        do_reset(1'b0, 1);
        issue(1, 0); issue(3, 0); issue(0, 0); issue(2, 0);
        expect_code(0, "R10 bank open one clock before closure");
        issue(0, 0); issue(2, 0);
        expect_code(1, "R10 bank closed after auto-precharge");

        // R11: first code held
        do_reset(1'b0, 0);
        issue(1, 0); issue(0, 0); issue(2, 1); issue(2, 0); issue(4, 0); nops(3);
        expect_code(1, "R11 first error held");

        // R12: priority
        do_reset(1'b0, 0);
        issue(1, 0); issue(2, 0); issue(2, 1);
        expect_code(1, "R12 closed bank wins over spacing");

        // random episodes against the model
        for (int ep = 0; ep < 60; ep++) begin
            do_reset(1'($urandom_range(1)), int'($urandom_range(3)));
            for (int k = 0; k < 40; k++) begin
                int r = int'($urandom_range(99));
                int c;
                if (r < 40) c = 0;
                else if (r < 56) c = 1;
                else if (r < 72) c = 2;
                else if (r < 82) c = 3;
                else if (r < 86) c = 4;
                else if (r < 95) c = 5;
                else c = 6 + int'($urandom_range(1));
                issue(c, int'($urandom_range(3)));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule